// File: doc/BRIEF.md
# Periodic Word Transmit Scheduler

This block decides when a downstream serializer should begin sending its next 32-bit word. It runs from a 1 MHz clock and watches a single enable input. A rising edge on that input starts a word at once. While the input stays high, words repeat at an interval chosen by an 8-bit code. Dropping the input stops transmission and throws away any repeat that is waiting.

Interval codes 1 to 255 give repeats every code × 10 ms. Code 0 selects back-to-back framing. In that mode the spacing is 36 bit times at the selected line rate: 32 data bits plus a 4-bit gap. At the low rate a bit lasts 80 clocks, and at the high rate it lasts 10 clocks.

The serializer reports its activity through a busy input. A start that comes due while the serializer is busy, or while the inter-word gap after busy is still running, is held back until the line is free. Such a start is delayed but never dropped.

After any reset there is a fixed quiet window. The master reset and the power-on reset are ORed into one reset, and the window follows either of them. During the window no start is issued. When the window closes, only the level of the enable input at that moment decides whether transmission begins.

Top module: `tx_pacer`

## Requirements
- R1: `start_pulse` is low while either `ext_rst` or `por_rst` is high. Releasing either one restarts the quiet window of R2.
- R2: After reset is released, no start is issued for `INHIBIT_MS`·`MS_TICKS` cycles. If `tx_enable` is high when the window ends, the first start appears on the (`INHIBIT_MS`·`MS_TICKS`+1)-th rising edge after release.
- R3: An edge on `tx_enable` inside the quiet window is not remembered. If `tx_enable` is low when the window ends, no start is issued.
- R4: Outside the window, with the line free, `start_pulse` becomes high at the first rising clock edge that samples `tx_enable` high after it was low.
- R5: `start_pulse` is high for exactly one clock cycle per word.
- R6: With `tx_enable` held high and an interval code from 1 to 255, consecutive starts are `code`·10·`MS_TICKS` cycles apart.
- R7: With interval code 0, consecutive starts are 36·`BIT_FAST` cycles apart when `fast_rate`=1, and 36·`BIT_SLOW` cycles apart when `fast_rate`=0.
- R8: While `tx_enable` is low, no start is issued and any waiting repeat is cancelled. Raising `tx_enable` again starts a word at once, as in R4.
- R9: The interval code and `fast_rate` are captured when a start is issued. A change between starts affects only the interval that follows the next start.
- R10: No start is issued in a cycle that follows `ser_busy` high. A start that comes due while busy is held. It is issued on the (4·bit+1)-th rising edge after `ser_busy` is seen low, where bit is the bit time selected by `fast_rate`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1 MHz timebase |
| ext_rst | input | 1 | Master reset, active high, synchronous |
| por_rst | input | 1 | Power-on reset, active high, ORed with `ext_rst` |
| tx_enable | input | 1 | Rising edge starts a word; high level allows repeats |
| interval_code | input | 8 | 0 selects back-to-back framing; 1–255 selects code × 10 ms |
| fast_rate | input | 1 | 1 selects the high line rate, 0 the low line rate |
| ser_busy | input | 1 | High while the serializer is shifting out a word |
| start_pulse | output | 1 | One-cycle request to begin a new word |

## Verification
The schedule is exercised with four enable patterns, and each one separates different behaviour:
- An enable edge that falls inside the quiet window, with the enable low at the window's end. This shows the window does not remember edges.
- An enable that rises inside a fresh window and then stays high. This confirms that the first start is timed only by the window length.
- Held enables with codes 3 and 1, and with code 0 at both rates. These measure each start-to-start spacing exactly. A code or rate change made mid-interval then shows whether the value was captured at the reload or read continuously.
- A serializer model whose busy period is far longer than the interval. This pins the deferred start to the gap count after busy falls, which tells apart holding a start from dropping or overlapping it.

// File: rtl/tx_pacer_pkg.sv
package tx_pacer_pkg;
    localparam int unsigned WORD_BITS  = 32;
    localparam int unsigned GAP_BITS   = 4;
    localparam int unsigned FRAME_BITS = WORD_BITS + GAP_BITS;
    localparam int unsigned CODE_W     = 8;

    typedef struct packed {
        logic en_prev;
        logic pend;
        logic start;
    } ctl_t;
endpackage

// File: rtl/tx_pacer_inhibit.sv
module tx_pacer_inhibit #(
    parameter int unsigned HOLD_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst,
    output logic active,
    output logic last
);
    localparam int unsigned IW = $clog2(HOLD_CYCLES + 1);

    typedef struct packed {
        logic [IW-1:0] cnt;
    } inh_t;

    inh_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.cnt != '0) s_d.cnt = s_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q.cnt <= IW'(HOLD_CYCLES);
        else     s_q     <= s_d;
    end

    assign active = (s_q.cnt != '0);
    assign last   = (s_q.cnt == IW'(1));

    AST_WINDOW_ONCE: assert property (@(posedge clk) disable iff (rst)
        !active |=> !active); // R2
endmodule

// File: rtl/tx_pacer_gap.sv
module tx_pacer_gap
    import tx_pacer_pkg::*;
#(
    parameter int unsigned BIT_FAST = 10,
    parameter int unsigned BIT_SLOW = 80
) (
    input  logic clk,
    input  logic rst,
    input  logic ser_busy,
    input  logic fast_rate,
    output logic line_free
);
    localparam int unsigned GAP_F = GAP_BITS * BIT_FAST;
    localparam int unsigned GAP_S = GAP_BITS * BIT_SLOW;
    localparam int unsigned GW    = $clog2(((GAP_F > GAP_S) ? GAP_F : GAP_S) + 1);

    typedef struct packed {
        logic          busy_prev;
        logic [GW-1:0] cnt;
    } gap_t;

    gap_t s_d, s_q;
    logic fall;

    assign fall = s_q.busy_prev & ~ser_busy;

    always_comb begin
        s_d           = s_q;
        s_d.busy_prev = ser_busy;
        if (fall)                s_d.cnt = fast_rate ? GW'(GAP_F - 1) : GW'(GAP_S - 1);
        else if (s_q.cnt != '0)  s_d.cnt = s_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign line_free = ~ser_busy & ~fall & (s_q.cnt == '0);

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        $past(ser_busy) |-> !$past(line_free)); // R10
endmodule

// File: rtl/tx_pacer_interval.sv
module tx_pacer_interval
    import tx_pacer_pkg::*;
#(
    parameter int unsigned MS_TICKS = 1000,
    parameter int unsigned BIT_FAST = 10,
    parameter int unsigned BIT_SLOW = 80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              cancel,
    input  logic [CODE_W-1:0] code,
    input  logic              fast_rate,
    output logic              expire
);
    localparam int unsigned TEN_MS  = 10 * MS_TICKS;
    localparam int unsigned LONGEST = ((1 << CODE_W) - 1) * TEN_MS;
    localparam int unsigned B2B_F   = FRAME_BITS * BIT_FAST;
    localparam int unsigned B2B_S   = FRAME_BITS * BIT_SLOW;
    localparam int unsigned B2B_MAX = (B2B_F > B2B_S) ? B2B_F : B2B_S;
    localparam int unsigned PMAX    = (LONGEST > B2B_MAX) ? LONGEST : B2B_MAX;
    localparam int unsigned TW      = $clog2(PMAX + 1);

    typedef struct packed {
        logic          run;
        logic [TW-1:0] cnt;
    } ivl_t;

    ivl_t s_d, s_q;
    logic [TW-1:0] period;

    always_comb begin
        if (code == '0) period = fast_rate ? TW'(B2B_F) : TW'(B2B_S);
        else            period = TW'(code) * TW'(TEN_MS);
    end

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.run = 1'b1;
            s_d.cnt = period - 1'b1;
        end else if (cancel) begin
            s_d.run = 1'b0;
            s_d.cnt = '0;
        end else if (s_q.run) begin
            if (s_q.cnt == '0) s_d.run = 1'b0;
            else               s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign expire = s_q.run & (s_q.cnt == '0);

    AST_LOAD_ARMS: assert property (@(posedge clk) disable iff (rst)
        load |=> (s_q.run && !expire)); // R6
    AST_CANCEL_STOPS: assert property (@(posedge clk) disable iff (rst)
        (cancel && !load) |=> !expire); // R8
endmodule

// File: rtl/tx_pacer.sv
module tx_pacer
    import tx_pacer_pkg::*;
#(
    parameter int unsigned MS_TICKS   = 1000,
    parameter int unsigned INHIBIT_MS = 500,
    parameter int unsigned BIT_FAST   = 10,
    parameter int unsigned BIT_SLOW   = 80
) (
    input  logic              clk,
    input  logic              ext_rst,
    input  logic              por_rst,
    input  logic              tx_enable,
    input  logic [CODE_W-1:0] interval_code,
    input  logic              fast_rate,
    input  logic              ser_busy,
    output logic              start_pulse
);
    localparam int unsigned HOLD_CYCLES = INHIBIT_MS * MS_TICKS;

    logic rst;
    logic inh_active, inh_last;
    logic line_free, expire;
    logic rise, ready, issue;
    ctl_t c_d, c_q;

    assign rst = ext_rst | por_rst;

    tx_pacer_inhibit #(.HOLD_CYCLES(HOLD_CYCLES)) u_inhibit (
        .clk    (clk),
        .rst    (rst),
        .active (inh_active),
        .last   (inh_last)
    );

    tx_pacer_gap #(.BIT_FAST(BIT_FAST), .BIT_SLOW(BIT_SLOW)) u_gap (
        .clk       (clk),
        .rst       (rst),
        .ser_busy  (ser_busy),
        .fast_rate (fast_rate),
        .line_free (line_free)
    );

    tx_pacer_interval #(.MS_TICKS(MS_TICKS), .BIT_FAST(BIT_FAST), .BIT_SLOW(BIT_SLOW)) u_interval (
        .clk       (clk),
        .rst       (rst),
        .load      (issue),
        .cancel    (~tx_enable),
        .code      (interval_code),
        .fast_rate (fast_rate),
        .expire    (expire)
    );

    assign rise  = tx_enable & ~c_q.en_prev;
    assign ready = line_free & ~inh_active & ~c_q.start;
    assign issue = tx_enable & ready & (c_q.pend | expire | (rise & ~inh_active));

    always_comb begin
        c_d         = c_q;
        c_d.en_prev = tx_enable;
        c_d.start   = issue;
        if (!tx_enable)                           c_d.pend = 1'b0;
        else if (issue)                           c_d.pend = 1'b0;
        else if (inh_last)                        c_d.pend = 1'b1;
        else if ((rise && !inh_active) || expire) c_d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '0;
        else     c_q <= c_d;
    end

    assign start_pulse = c_q.start;

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse); // R5
    AST_QUIET_WINDOW: assert property (@(posedge clk) disable iff (rst)
        inh_active |-> !start_pulse); // R2
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !tx_enable |=> !start_pulse); // R8
    AST_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> !$past(ser_busy)); // R10
    AST_RESET_LOW: assert property (@(posedge clk)
        $past(rst) |-> !start_pulse); // R1
endmodule

// File: tb/tx_pacer_test.sv
`timescale 1ns/1ps
module tx_pacer_test;
    localparam int CLK_PERIOD = 1000;
    localparam int MS   = 4;
    localparam int INHM = 5;
    localparam int BF   = 2;
    localparam int BS   = 16;
    localparam int INH  = INHM * MS;
    localparam int GF   = 4 * BF;
    localparam int WD   = 20000;

    logic clk = 1'b0;
    logic ext_rst = 1'b0, por_rst = 1'b1, tx_enable = 1'b0;
    logic [7:0] interval_code = 8'd3;
    logic fast_rate = 1'b1, ser_busy = 1'b0;
    logic start_pulse;

    int cyc = 0;
    int n_run = 0, n_fail = 0, starts_seen = 0;
    int exp_at[$];
    string exp_req[$];
    logic prev_start = 1'b0;
    int ser_len = 0, ser_cnt = 0;

    tx_pacer #(.MS_TICKS(MS), .INHIBIT_MS(INHM), .BIT_FAST(BF), .BIT_SLOW(BS)) uut (
        .clk(clk), .ext_rst(ext_rst), .por_rst(por_rst), .tx_enable(tx_enable),
        .interval_code(interval_code), .fast_rate(fast_rate), .ser_busy(ser_busy),
        .start_pulse(start_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic expect_at(input int at, input string req);
        exp_at.push_back(at);
        exp_req.push_back(req);
    endtask

    task automatic tick_until(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (prev_start) check(start_pulse == 1'b0, "R5 single-cycle pulse", int'(start_pulse), 0);
        if (start_pulse) begin
            starts_seen++;
            if (exp_at.size() == 0) begin
                check(1'b0, "R2/R3/R8 unexpected start", cyc, -1);
            end else begin
                int e;
                string r;
                e = exp_at.pop_front();
                r = exp_req.pop_front();
                check(cyc == e, r, cyc, e);
            end
        end
        prev_start = start_pulse;
    end

    // serializer model
    always @(negedge clk) begin
        if (start_pulse && ser_len > 0) begin
            ser_busy = 1'b1;
            ser_cnt  = ser_len;
        end else if (ser_cnt > 0) begin
            ser_cnt--;
            if (ser_cnt == 0) ser_busy = 1'b0;
        end
    end

    task automatic run_all();
        int r, k, saved;
        repeat (3) @(negedge clk);
        check(start_pulse == 1'b0, "R1 low during power-on reset", int'(start_pulse), 0);
        por_rst = 1'b0;
        r = cyc;
        repeat (3) @(negedge clk);
        tx_enable = 1'b1;
        repeat (2) @(negedge clk);
        tx_enable = 1'b0;
        tick_until(r + INH + 10);
        check(starts_seen == 0, "R3 edge in window forgotten", starts_seen, 0);

        @(negedge clk);
        tx_enable = 1'b1;
        k = cyc;
        expect_at(k + 1, "R4 edge start");
        expect_at(k + 121, "R6 code 3 repeat");
        expect_at(k + 241, "R6 code 3 repeat");
        tick_until(k + 291);
        tx_enable = 1'b0;
        saved = starts_seen;
        tick_until(k + 381);
        check(starts_seen == saved, "R8 no start while low", starts_seen, saved);

        @(negedge clk);
        tx_enable = 1'b1;
        k = cyc;
        expect_at(k + 1, "R8 re-raise starts at once");
        expect_at(k + 121, "R9 old code kept");
        expect_at(k + 161, "R9 new code at reload");
        tick_until(k + 30);
        interval_code = 8'd1;
        tick_until(k + 171);
        tx_enable = 1'b0;
        repeat (5) @(negedge clk);

        interval_code = 8'd0;
        fast_rate = 1'b1;
        @(negedge clk);
        tx_enable = 1'b1;
        k = cyc;
        expect_at(k + 1, "R4 edge start");
        expect_at(k + 73, "R7 fast back-to-back");
        expect_at(k + 145, "R7 fast back-to-back");
        expect_at(k + 721, "R7 slow back-to-back");
        tick_until(k + 75);
        fast_rate = 1'b0;
        tick_until(k + 731);
        tx_enable = 1'b0;
        repeat (5) @(negedge clk);

        interval_code = 8'd1;
        fast_rate = 1'b1;
        ser_len = 200;
        repeat (2) @(negedge clk);
        tx_enable = 1'b1;
        k = cyc;
        expect_at(k + 1, "R4 edge start");
        expect_at(k + 210, "R10 held until gap");
        expect_at(k + 419, "R10 held until gap");
        tick_until(k + 430);
        tx_enable = 1'b0;
        ser_len = 0;
        tick_until(k + 640);

        ext_rst = 1'b1;
        repeat (3) @(negedge clk);
        check(start_pulse == 1'b0, "R1 low during master reset", int'(start_pulse), 0);
        ext_rst = 1'b0;
        r = cyc;
        repeat (5) @(negedge clk);
        tx_enable = 1'b1;
        expect_at(r + INH + 1, "R2 first start after window");
        expect_at(r + INH + 41, "R6 code 1 repeat");
        tick_until(r + INH + 46);
        tx_enable = 1'b0;
        repeat (10) @(negedge clk);
        check(exp_at.size() == 0, "R4/R6/R7/R9/R10 all expected starts seen", exp_at.size(), 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (WD) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog R1-chain: actual %0d expected %0d", cyc, WD);
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule